// File: doc/BRIEF.md
# Video Sync Timing Generator

This block produces horizontal, vertical and field timing for a standard-definition video encoder front end. It runs on one 27 MHz clock and takes an 8-bit 4:2:2 byte stream in which Cb, Y, Cr and Y samples arrive one per clock. It keeps a byte counter inside each line and a line counter inside each frame. It also keeps a field flag and a two-bit tag that names the component of the current byte. Downstream logic uses these to steer the luma and chroma paths.

Three sync sources share one counter engine. In decode mode the block finds end-of-active-video codes in the byte stream and aligns to them. In master mode it runs freely. In both of these modes it drives a horizontal sync and a shared field/vertical pin. In slave mode those two pins are inputs, and the counters lock to them. A configuration bit chooses whether the shared pin carries the field flag or a vertical sync. A static input chooses the clock edge on which the byte stream is sampled. The block supports 525-line and 625-line standards. After reset it is in decode mode with 525-line timing.

Top module: `sdv_sync_gen`

## Requirements
- R1: After reset the block is in decode mode, 525-line timing, field-flag select on the shared pin. pix_cnt, line_cnt, field and phase are all 0 and sync_oe is 1.
- R2: With no alignment event, pix_cnt counts 0 to LEN-1 and then returns to 0. LEN is 1716 (525-line) or 1728 (625-line). line_cnt advances at each return to 0 and goes back to 0 after line LINES-1. LINES defaults to 525 or 625.
- R3: phase advances by one every clock in the order 0=Cb, 1=Y, 2=Cr, 3=Y. It is 0 on the first byte after a line wrap, an accepted end code or a slave sync edge.
- R4: In decode mode the bytes FF 00 00 XY with XY bit 4 set form an end code. The byte after XY has pix_cnt 0 and phase 0, and field takes XY bit 6. If XY bit 6 goes 1 to 0, line_cnt becomes 0. If it goes 0 to 1, line_cnt becomes HALF=(LINES+1)/2. Otherwise line_cnt advances. When XY bit 4 is clear, the counters are not touched.
- R5: In decode mode with vertical-sync select, fv_out equals XY bit 5 of the last accepted end code.
- R6: In master mode, field is 0 for lines below HALF and 1 from HALF on. The internal vertical sync is high in lines 0 to VS_LINES-1 and in lines HALF to HALF+VS_LINES-1.
- R7: hs_out is high while pix_cnt < HS_W. sync_oe is 1 in decode and master modes and 0 in slave mode.
- R8: fv_out carries field when cfg_vs_sel=0 and the vertical sync when cfg_vs_sel=1.
- R9: In slave mode a rising edge of hs_in sets pix_cnt and phase to 0 on the next byte. Holding hs_in high has no further effect, and hs_in has no effect in decode mode. With field select, fv_in is sampled at that edge and moves field and line_cnt by the same rules that R4 gives for XY bit 6.
- R10: In slave mode with vertical-sync select, a rise of fv_in seen at an hs_in edge toggles field. line_cnt then becomes HALF if the new field is 1, or 0 if it is 0. Otherwise line_cnt advances.
- R11: With edge_sel=0, din is taken at the rising clock edge. With edge_sel=1, din is taken at the falling edge before it.
- R12: A cycle with cfg_we=1 loads the mode (0 decode, 1 master, 2 slave, 3 master), cfg_625 (1 selects 625-line timing) and cfg_vs_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| edge_sel | input | 1 | Static data sampling edge: 0 rising, 1 falling |
| cfg_we | input | 1 | Load strobe for the configuration fields |
| cfg_mode | input | 2 | Sync source: 0 decode, 1 or 3 master, 2 slave |
| cfg_625 | input | 1 | 1 selects 625-line timing |
| cfg_vs_sel | input | 1 | Shared pin function: 0 field flag, 1 vertical sync |
| din | input | 8 | Multiplexed 4:2:2 byte stream |
| hs_in | input | 1 | External horizontal sync (slave mode) |
| fv_in | input | 1 | External field or vertical sync (slave mode) |
| hs_out | output | 1 | Horizontal sync, high for HS_W bytes from line start |
| fv_out | output | 1 | Field flag or vertical sync |
| sync_oe | output | 1 | Drive enable for the two sync pins |
| pix_cnt | output | 11 | Byte position in the line |
| line_cnt | output | 10 | Line position in the frame |
| field | output | 1 | 0 odd field, 1 even field |
| phase | output | 2 | Component tag: 0 Cb, 1 Y, 2 Cr, 3 Y |

## Verification
A wrong byte counter shows at once as a shifted phase tag and a moved hs_out pulse. A miscounted line length shows only at the next wrap, so the master runs follow a whole frame byte by byte. A stale field flag or line alignment shows in line_cnt on the byte right after the end code or sync edge that should have moved it. A bad sampling-edge mux shows as an end code that is lost or found at the wrong edge, because the bench changes din in the middle of each cycle.

// File: rtl/sdv_sync_gen.sv
module sdv_sync_gen #(
  parameter int LEN_525   = 1716,
  parameter int LEN_625   = 1728,
  parameter int LINES_525 = 525,
  parameter int LINES_625 = 625,
  parameter int HS_W      = 128,
  parameter int VS_LINES  = 3,
  localparam int PW = $clog2(LEN_625),
  localparam int LW = $clog2(LINES_625)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_sel,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_625,
  input  logic          cfg_vs_sel,
  input  logic [7:0]    din,
  input  logic          hs_in,
  input  logic          fv_in,
  output logic          hs_out,
  output logic          fv_out,
  output logic          sync_oe,
  output logic [PW-1:0] pix_cnt,
  output logic [LW-1:0] line_cnt,
  output logic          field,
  output logic [1:0]    phase
);
  localparam logic [1:0] M_DEC = 2'd0, M_SLV = 2'd2;

  logic [1:0] mode_r;
  logic       std_r, vsel_r, vbit, hs_prev, fv_prev;
  logic [7:0] din_n, p1, p2, p3;

  wire [7:0]    smp   = edge_sel ? din_n : din;
  wire          dec   = (mode_r == M_DEC);
  wire          slv   = (mode_r == M_SLV);
  wire          mst   = mode_r[0];
  wire [PW-1:0] len   = std_r ? PW'(LEN_625) : PW'(LEN_525);
  wire [LW-1:0] lines = std_r ? LW'(LINES_625) : LW'(LINES_525);
  wire [LW-1:0] half  = std_r ? LW'((LINES_625 + 1) / 2) : LW'((LINES_525 + 1) / 2);

  wire eav_hit = dec && p3 == 8'hFF && p2 == 8'h00 && p1 == 8'h00 && smp[4];
  wire hs_edge = slv && hs_in && !hs_prev;
  wire pix_end = pix_cnt >= len - PW'(1);

  wire [LW-1:0] line_inc = (line_cnt >= lines - LW'(1)) ? '0 : line_cnt + LW'(1);
  wire          fnew     = eav_hit ? smp[6] : fv_in;
  wire [LW-1:0] line_fid = (!fnew && field) ? '0 : (fnew && !field) ? half : line_inc;

  wire in_vs = (line_cnt < LW'(VS_LINES)) ||
               (line_cnt >= half && line_cnt < half + LW'(VS_LINES));
  wire vs    = dec ? vbit : in_vs;

  assign hs_out  = pix_cnt < PW'(HS_W);
  assign fv_out  = vsel_r ? vs : field;
  assign sync_oe = !slv;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) din_n <= '0;
    else        din_n <= din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r   <= M_DEC;
      std_r    <= 1'b0;
      vsel_r   <= 1'b0;
      p1       <= '0;
      p2       <= '0;
      p3       <= '0;
      hs_prev  <= 1'b0;
      fv_prev  <= 1'b0;
      vbit     <= 1'b0;
      pix_cnt  <= '0;
      line_cnt <= '0;
      field    <= 1'b0;
      phase    <= '0;
    end else begin
      if (cfg_we) begin
        mode_r <= cfg_mode;
        std_r  <= cfg_625;
        vsel_r <= cfg_vs_sel;
      end
      p1      <= smp;
      p2      <= p1;
      p3      <= p2;
      hs_prev <= hs_in;
      pix_cnt <= pix_cnt + PW'(1);
      phase   <= phase + 2'd1;
      if (eav_hit) begin
        pix_cnt  <= '0;
        phase    <= '0;
        field    <= smp[6];
        vbit     <= smp[5];
        line_cnt <= line_fid;
      end else if (hs_edge) begin
        pix_cnt <= '0;
        phase   <= '0;
        fv_prev <= fv_in;
        if (!vsel_r) begin
          field    <= fv_in;
          line_cnt <= line_fid;
        end else if (fv_in && !fv_prev) begin
          field    <= !field;
          line_cnt <= field ? '0 : half;
        end else begin
          line_cnt <= line_inc;
        end
      end else if (pix_end) begin
        pix_cnt  <= '0;
        phase    <= '0;
        line_cnt <= line_inc;
        if (mst) field <= (line_inc >= half);
      end
    end
  end
endmodule

// File: rtl/sdv_sync_gen_chk.sv
module sdv_sync_gen_chk #(
  parameter int PW = 11,
  parameter int LW = 10,
  parameter int LEN_MAX = 1728,
  parameter int LINES_MAX = 625
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_r,
  input logic          eav_hit,
  input logic          hs_in,
  input logic          sync_oe,
  input logic          hs_out,
  input logic [PW-1:0] pix_cnt,
  input logic [LW-1:0] line_cnt,
  input logic [1:0]    phase
);
  // R2
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_cnt < PW'(LEN_MAX)) && (line_cnt < LW'(LINES_MAX)));

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase == $past(phase) + 2'd1) || (phase == 2'd0));

  // R4
  eav_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eav_hit |=> (pix_cnt == '0) && (phase == 2'd0));

  // R9
  slave_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r == 2'd2 && hs_in && !$past(hs_in)) |=> (pix_cnt == '0) && (phase == 2'd0));

  // R7
  hs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_oe && $rose(hs_out)) |-> (pix_cnt == '0));
endmodule

bind sdv_sync_gen sdv_sync_gen_chk #(
  .PW(PW), .LW(LW), .LEN_MAX(LEN_625), .LINES_MAX(LINES_625)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_r(mode_r), .eav_hit(eav_hit), .hs_in(hs_in),
  .sync_oe(sync_oe), .hs_out(hs_out), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
  .phase(phase)
);

// File: tb/sdv_sync_gen_test.sv
`timescale 1ns/100ps
module sdv_sync_gen_test;
  localparam int L525 = 1716, L625 = 1728, N525 = 9, N625 = 11, HSW = 128, VSL = 3;
  localparam int H525 = (N525 + 1) / 2, H625 = (N625 + 1) / 2;

  logic clk = 0, rst_n = 0, edge_sel = 0, cfg_we = 0, cfg_625 = 0, cfg_vs_sel = 0;
  logic [1:0] cfg_mode = 0;
  logic [7:0] din = 8'h10;
  logic hs_in = 0, fv_in = 0;
  logic hs_out, fv_out, sync_oe, field;
  logic [10:0] pix_cnt;
  logic [9:0] line_cnt;
  logic [1:0] phase;
  int n_run = 0, n_fail = 0;

  sdv_sync_gen #(.LINES_525(N525), .LINES_625(N625), .HS_W(HSW), .VS_LINES(VSL)) uut (
    .clk(clk), .rst_n(rst_n), .edge_sel(edge_sel), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_625(cfg_625), .cfg_vs_sel(cfg_vs_sel), .din(din), .hs_in(hs_in), .fv_in(fv_in),
    .hs_out(hs_out), .fv_out(fv_out), .sync_oe(sync_oe), .pix_cnt(pix_cnt),
    .line_cnt(line_cnt), .field(field), .phase(phase));

  always #2.5 clk = ~clk;

  initial begin
    #(5.0 * 190000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_cfg(int m, bit s, bit v);
    tick();
    cfg_mode = 2'(m); cfg_625 = s; cfg_vs_sel = v; cfg_we = 1;
    tick();
    cfg_we = 0;
  endtask

  task automatic put(logic [7:0] b, bit glitch);
    tick();
    din = b;
    #2.5 if (glitch) din = 8'h10;
  endtask

  task automatic send_code(logic [7:0] xy, bit glitch, bit hit, string req);
    int p;
    tick();
    p = pix_cnt;
    din = 8'hFF;
    #2.5 if (glitch) din = 8'h10;
    put(8'h00, glitch);
    put(8'h00, glitch);
    put(xy, glitch);
    tick();
    din = 8'h10;
    chk(req, "pix after code", pix_cnt, hit ? 0 : (p + 4) % L525);
    if (hit) chk(req, "phase after code", phase, 0);
  endtask

  task automatic test_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1", "pix", pix_cnt, 0);
    chk("R1", "line", line_cnt, 0);
    chk("R1", "field", field, 0);
    chk("R1", "phase", phase, 0);
    chk("R1", "sync_oe", sync_oe, 1);
    chk("R1", "fv_out", fv_out, 0);
    repeat (L525 - 1) @(posedge clk);
    #1;
    chk("R2", "pix at line end", pix_cnt, L525 - 1);
    chk("R3", "phase at line end", phase, 3);
    tick();
    chk("R2", "pix after wrap", pix_cnt, 0);
    chk("R2", "line after wrap", line_cnt, 1);
  endtask

  task automatic test_decode();
    int p;
    send_code(8'hD0, 0, 1, "R4");
    chk("R4", "line on F rise", line_cnt, H525);
    chk("R4", "field on F rise", field, 1);
    send_code(8'h90, 0, 1, "R4");
    chk("R4", "line on F fall", line_cnt, 0);
    chk("R4", "field on F fall", field, 0);
    send_code(8'h90, 0, 1, "R4");
    chk("R4", "line advance", line_cnt, 1);
    send_code(8'hB0, 0, 1, "R5");
    chk("R8", "fv_out field select", fv_out, 0);
    set_cfg(0, 0, 1);
    chk("R5", "fv_out V bit set", fv_out, 1);
    send_code(8'h90, 0, 1, "R5");
    chk("R5", "fv_out V bit clear", fv_out, 0);
    chk("R4", "line advance 2", line_cnt, 3);
    send_code(8'h80, 0, 0, "R4");
    chk("R4", "line kept on start code", line_cnt, 3);
    tick();
    p = pix_cnt;
    hs_in = 1;
    tick();
    chk("R9", "hs_in ignored in decode", pix_cnt, (p + 1) % L525);
    hs_in = 0;
    send_code(8'h90, 1, 0, "R11");
    edge_sel = 1;
    send_code(8'h90, 1, 1, "R11");
    edge_sel = 0;
    tick();
  endtask

  task automatic run_master(int m, bit s, bit v, string req);
    int len, lines, half, ep, el, guard;
    int e_pl, e_f, e_ph, e_hs, e_fv;
    bit ef, evs;
    len = s ? L625 : L525;
    lines = s ? N625 : N525;
    half = s ? H625 : H525;
    set_cfg(m, s, v);
    tick();
    guard = 0;
    forever begin
      tick();
      guard++;
      if ((pix_cnt == 0 && line_cnt == 0) || guard > 50000) break;
    end
    ep = 0; el = 0; e_pl = 0; e_f = 0; e_ph = 0; e_hs = 0; e_fv = 0;
    for (int i = 0; i < len * lines + 8; i++) begin
      ef = (el >= half);
      evs = (el < VSL) || (el >= half && el < half + VSL);
      if (pix_cnt != ep || line_cnt != el) e_pl++;
      if (field != ef) e_f++;
      if (phase != 2'(ep % 4)) e_ph++;
      if (hs_out != (ep < HSW) || sync_oe != 1) e_hs++;
      if (fv_out != (v ? evs : ef)) e_fv++;
      tick();
      ep++;
      if (ep == len) begin ep = 0; el = (el == lines - 1) ? 0 : el + 1; end
    end
    chk("R2", {req, " counter mismatches"}, e_pl, 0);
    chk("R6", {req, " field mismatches"}, e_f, 0);
    chk("R3", {req, " phase mismatches"}, e_ph, 0);
    chk("R7", {req, " hs_out/sync_oe mismatches"}, e_hs, 0);
    chk("R8", {req, " fv_out mismatches"}, e_fv, 0);
  endtask

  task automatic slave_edge(bit fv, int exp_line, int exp_field, string req);
    int l;
    tick();
    l = line_cnt;
    fv_in = fv; hs_in = 1;
    tick();
    chk(req, "pix at hs edge", pix_cnt, 0);
    chk("R3", "phase at hs edge", phase, 0);
    chk(req, "line at hs edge", line_cnt, exp_line < 0 ? ((l >= N525 - 1) ? 0 : l + 1) : exp_line);
    chk(req, "field at hs edge", field, exp_field);
    tick();
    chk("R9", "pix with hs held", pix_cnt, 1);
    hs_in = 0;
    repeat (3) tick();
  endtask

  task automatic test_slave();
    set_cfg(2, 0, 0);
    chk("R7", "sync_oe in slave", sync_oe, 0);
    slave_edge(0, -1, 0, "R9");
    slave_edge(1, H525, 1, "R9");
    slave_edge(1, H525 + 1, 1, "R9");
    slave_edge(0, 0, 0, "R9");
    set_cfg(2, 0, 1);
    slave_edge(1, H525, 1, "R10");
    slave_edge(1, H525 + 1, 1, "R10");
    slave_edge(0, H525 + 2, 1, "R10");
    slave_edge(1, 0, 0, "R10");
  endtask

  initial begin
    test_reset();
    test_decode();
    run_master(1, 0, 0, "R12 mode1 525");
    run_master(3, 1, 1, "R12 mode3 625");
    test_slave();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule